// File: doc/BRIEF.md
# Interrupt in-service priority tracker

This block keeps a record of which maskable interrupt priority levels are being serviced at any moment. There are eight levels. Level 0 is the most urgent and level 7 the least. When the interrupt controller accepts a maskable request, the block sets the bit for that request's level. The bit stays set for as long as the handler runs.

When a maskable handler returns, the block clears one bit: the set bit with the lowest number, which is the most urgent level in service. Returns from non-maskable handlers and returns from exception processing arrive on their own input and never change the record.

The block also reports two summary values:
- a flag that is high when any level is in service;
- the encoded most urgent level in service, which the priority arbiter uses to hold back new requests that are not more urgent.

Software can read the record, either as a whole byte or one bit at a time, but it cannot write it. The read view already includes a bit being acknowledged in the same cycle. Request arbitration, vectoring and the processor pipeline are handled elsewhere.

Top module: `isr_level_tracker`

## Requirements
- R1: After reset, `in_service` is 8'h00, `any_in_service` is 0 and `rd_byte` is 8'h00 while no acknowledge is presented.
- R2: When `ack_valid` is high with `ack_level` = n, bit n of `in_service` is 1 from the next clock edge on. It stays 1 until a maskable return clears it.
- R3: A `ret_maskable` pulse clears exactly one bit of `in_service`, the lowest-numbered set bit (level 0 is the highest priority), and leaves every other bit unchanged.
- R4: A `ret_other` pulse on its own has no effect: `in_service` keeps its value across that edge.
- R5: A `ret_maskable` pulse that arrives while `in_service` is 8'h00 is ignored, and `in_service` stays 8'h00.
- R6: When an acknowledge and a maskable return arrive in the same cycle, the clear is applied to the old value first and the new bit is set afterwards. If the acknowledged level equals the cleared level, that bit remains 1.
- R7: `any_in_service` is 1 exactly when at least one bit of `in_service` is 1.
- R8: While `any_in_service` is 1, `top_level` holds the index of the lowest-numbered set bit of `in_service`.
- R9: `rd_byte` equals `in_service`, with bit `ack_level` also set in any cycle where `ack_valid` is high. This makes a same-cycle acknowledge visible to a read.
- R10: `rd_bit` equals bit `rd_sel` of `rd_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_valid | input | 1 | Maskable request acknowledged this cycle |
| ack_level | input | 3 | Priority level of the acknowledged request |
| ret_maskable | input | 1 | Return from a maskable handler |
| ret_other | input | 1 | Return from a non-maskable handler or exception (no effect) |
| rd_sel | input | 3 | Bit index for the single-bit read |
| in_service | output | 8 | Registered in-service record, bit n = level n |
| any_in_service | output | 1 | At least one level in service |
| top_level | output | 3 | Most urgent level in service, valid when any_in_service is 1 |
| rd_byte | output | 8 | Byte read view including a same-cycle acknowledge |
| rd_bit | output | 1 | Single-bit read view |

## Verification
The hardest situation to reach from the ports is a return that coincides with an acknowledge. It matters most when the acknowledged level is the same level the return clears, and when the record is already holding several nested levels. The stimulus first builds deep nesting through a chain of directed acknowledges. It then fires the combined events at the lowest set level, at a level above it and at a level below it. After that, a long random stream of acknowledges and both kinds of return is compared every clock against a behavioural model. That stream also covers returns on an empty record and returns from non-maskable handlers.

// File: rtl/isr_level_tracker.sv
module isr_level_tracker #(
  parameter int LEVELS = 8,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_valid,
  input  logic [LVL_W-1:0]  ack_level,
  input  logic              ret_maskable,
  input  logic              ret_other,
  input  logic [LVL_W-1:0]  rd_sel,
  output logic [LEVELS-1:0] in_service,
  output logic              any_in_service,
  output logic [LVL_W-1:0]  top_level,
  output logic [LEVELS-1:0] rd_byte,
  output logic              rd_bit
);

  logic [LEVELS-1:0] isr_q;
  logic [LEVELS-1:0] ack_mask;
  logic [LEVELS-1:0] lowest_mask;
  logic [LEVELS-1:0] after_ret;

  assign ack_mask    = ack_valid ? (LEVELS'(1) << ack_level) : '0;
  assign lowest_mask = isr_q & (~isr_q + LEVELS'(1));
  assign after_ret   = ret_maskable ? (isr_q & ~lowest_mask) : isr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= after_ret | ack_mask;
  end

  always_comb begin
    top_level = '0;
    for (int i = LEVELS - 1; i >= 0; i--)
      if (isr_q[i]) top_level = LVL_W'(i);
  end

  assign in_service     = isr_q;
  assign any_in_service = |isr_q;
  assign rd_byte        = isr_q | ack_mask;
  assign rd_bit         = rd_byte[rd_sel];

endmodule

// File: rtl/isr_level_tracker_checker.sv
module isr_level_tracker_checker #(
  parameter int LEVELS = 8,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_valid,
  input logic [LVL_W-1:0]  ack_level,
  input logic              ret_maskable,
  input logic              ret_other,
  input logic [LEVELS-1:0] in_service,
  input logic              any_in_service,
  input logic [LVL_W-1:0]  top_level,
  input logic [LEVELS-1:0] rd_byte
);

  a_r2_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> in_service[$past(ack_level)]);

  a_r3_ret_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_maskable && !ack_valid && (|in_service))
      |=> ($countones(in_service) == $countones($past(in_service)) - 1));

  a_r4_other_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_other && !ret_maskable && !ack_valid) |=> $stable(in_service));

  a_r5_empty_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_maskable && !ack_valid && in_service == '0) |=> (in_service == '0));

  a_r7_any_flag: assert property (@(posedge clk) disable iff (!rst_n)
    any_in_service == (in_service != '0));

  a_r8_top_level: assert property (@(posedge clk) disable iff (!rst_n)
    any_in_service |-> (in_service[top_level] &&
      ((in_service & ((LEVELS'(1) << top_level) - LEVELS'(1))) == '0)));

  a_r9_read_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> rd_byte[ack_level]);

endmodule

bind isr_level_tracker isr_level_tracker_checker #(.LEVELS(LEVELS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_level(ack_level),
  .ret_maskable(ret_maskable), .ret_other(ret_other), .in_service(in_service),
  .any_in_service(any_in_service), .top_level(top_level), .rd_byte(rd_byte)
);

// File: tb/isr_level_tracker_tb.sv
module isr_level_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_level = '0;
  logic       ret_maskable = 1'b0;
  logic       ret_other = 1'b0;
  logic [2:0] rd_sel = '0;
  logic [7:0] in_service;
  logic       any_in_service;
  logic [2:0] top_level;
  logic [7:0] rd_byte;
  logic       rd_bit;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit [7:0] model = '0;

  always #5 clk = ~clk;

  isr_level_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_level(ack_level),
    .ret_maskable(ret_maskable), .ret_other(ret_other), .rd_sel(rd_sel),
    .in_service(in_service), .any_in_service(any_in_service),
    .top_level(top_level), .rd_byte(rd_byte), .rd_bit(rd_bit)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, actual, expected, $time);
    end
  endtask

  function automatic int lowest_set(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic check_regs();
    check("R2/R3/R4/R5/R6 in_service", in_service, model);
    check("R7 any_in_service", any_in_service, model != 0);
    if (model != 0) check("R8 top_level", top_level, lowest_set(model));
  endtask

  task automatic step(bit a, int lvl, bit rm, bit ro, int sel);
    bit [7:0] view;
    @(negedge clk);
    ack_valid = a; ack_level = 3'(lvl); ret_maskable = rm; ret_other = ro; rd_sel = 3'(sel);
    #1;
    view = model;
    if (a) view[lvl] = 1'b1;
    check("R9 rd_byte", rd_byte, view);
    check("R10 rd_bit", rd_bit, view[sel]);
    @(posedge clk);
    if (rm && model != 0) model[lowest_set(model)] = 1'b0;
    if (a) model[lvl] = 1'b1;
    #1;
    check_regs();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset in_service", in_service, 0);
    check("R1 reset any", any_in_service, 0);
    check("R1 reset rd_byte", rd_byte, 0);
    @(negedge clk) rst_n = 1'b1;
    // R5: return on empty record
    step(0, 0, 1, 0, 0);
    // R2: nest levels 7, 5, 2
    step(1, 7, 0, 0, 7);
    step(1, 5, 0, 0, 5);
    step(1, 2, 0, 0, 3);
    step(0, 0, 0, 0, 2);
    // R4: other returns leave the record unchanged
    step(0, 0, 0, 1, 2);
    step(0, 0, 0, 1, 5);
    // R6: combined ack and return at the lowest set level, below it and above it
    step(1, 2, 1, 0, 2);
    step(1, 0, 1, 0, 0);
    step(1, 6, 1, 0, 6);
    // R3: drain one level per return
    repeat (5) step(0, 0, 1, 0, 7);
    // R5 again after draining
    step(0, 0, 1, 1, 0);
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 45, int'($urandom_range(0, 7)), (r % 3) == 0, (r % 4) == 1,
           int'($urandom_range(0, 7)));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule